// File: doc/BRIEF.md
# Display Writeback Frame Controller

This block holds the configuration of a display writeback engine and runs its frame sequence. Software programs a destination pointer, a line pitch and the image size through a 32-bit register port addressed by word index. It then launches a frame with a start bit that clears itself. While the frame runs, the block accepts lines that the compositor offers and counts each line that the memory writer reports as committed. It closes the frame when the count reaches the programmed height.

A busy flag covers the whole frame. An abort bit ends a frame early. A powerdown bit shuts the line memory down and holds the engine idle. A one-cycle vertical-start pulse marks the launch of a frame, and can also be requested at its natural end. The interrupt output is a level: it is high while the interrupt is enabled and the engine is idle. Software acknowledges it by clearing the enable. The packing, tiling and memory datapath sit outside the block and only read the exported configuration.

Top module: `wbk_ctrl`

## Requirements
- R1: After reset every stored field is zero and the control word (index 3) reads 0x5440_0000. Its bits 31:24 always read 0x54 and bits 23:22 always read 0b01.
- R2: Word index 0 holds the destination pointer, with bits 1:0 forced to 0. Index 1 holds the pitch, with bits 3:0 forced to 0. Index 2 holds the height in bits 31:16 and the width in bits 15:0. Index 4 reads the line count. Indices 5 to 7 read 0.
- R3: A write to the control word with bit 0 set, while idle, not powered down and not aborting, sets busy (control bit 1) at the next edge and clears the line count to 0. Bit 0 always reads 0.
- R4: A start written while busy is ignored: busy stays 1, the line count keeps its value and no vertical-start pulse follows.
- R5: Each cycle with line_wr_done high while busy and count below height adds 1 to the count. The strobe has no effect while idle, and the count holds after a frame.
- R6: When the count equals the height while busy, busy falls at the next edge. A frame of height 0 stays busy for exactly one cycle.
- R7: vstart is high for one cycle directly after an accepted start. When control bit 15 is set, it is also high for one cycle directly after busy falls at a frame's natural end. There is no pulse for an abort or for a start that is ignored.
- R8: irq equals control bit 2 AND NOT busy. Writing bit 2 as 0 lowers irq.
- R9: A control write with bit 14 set clears busy at the next edge, and the line count then stays frozen. Bit 14 always reads 0. If bit 14 is set in the same write as bit 0, the start is ignored.
- R10: Control bit 21 is stored and read back. While it is set, busy is 0. A write that sets it clears busy at the same edge, and starts are ignored.
- R11: line_accept is high exactly when line_valid is high and the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| line_valid | input | 1 | Compositor offers a line |
| line_accept | output | 1 | Line taken by the engine |
| line_wr_done | input | 1 | One line committed to memory |
| vstart | output | 1 | Vertical-start pulse |
| irq | output | 1 | Idle interrupt level |
| cfg_dst | output | PTR_W | Destination pointer |
| cfg_pitch | output | PTR_W | Line pitch in bytes |
| cfg_width | output | DIM_W | Image width |
| cfg_height | output | DIM_W | Image height |
| cfg_pwrdn | output | 1 | Line memory powerdown |

## Verification
Frames are run with heights of three, two and zero, with the end-of-frame pulse both enabled and disabled. These runs separate the launch pulse from the end pulse, and show the single busy cycle of an empty frame. Starts are also issued in conditions where they must be refused: during a frame, together with an abort, and under powerdown. The refusals are told apart from real launches by the line count, which must not reset, and by the absence of a vertical-start pulse. Commit strobes are sent while idle and after an abort, which shows that the count only moves inside a live frame. Misaligned pointer and pitch writes show the forced low bits.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
    localparam int REG_W   = 32;
    localparam int IDX_W   = 3;
    localparam int DIM_FLD = 16;

    localparam logic [IDX_W-1:0] IX_DST   = 3'd0;
    localparam logic [IDX_W-1:0] IX_PITCH = 3'd1;
    localparam logic [IDX_W-1:0] IX_DIM   = 3'd2;
    localparam logic [IDX_W-1:0] IX_CTRL  = 3'd3;
    localparam logic [IDX_W-1:0] IX_PROG  = 3'd4;

    localparam int B_GO     = 0;
    localparam int B_BUSY   = 1;
    localparam int B_IEN    = 2;
    localparam int B_KILL   = 14;
    localparam int B_VS_EOF = 15;
    localparam int B_PWRDN  = 21;

    localparam logic [7:0] ID_HI = 8'h54;
    localparam logic [1:0] ID_LO = 2'b01;

    localparam int DST_ALIGN   = 2;
    localparam int PITCH_ALIGN = 4;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_st_e;
endpackage

// File: rtl/wbk_regs.sv
module wbk_regs
    import wbk_pkg::*;
#(
    parameter int DIM_W = 16,
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic [DIM_W-1:0] progress,
    output logic             start_req,
    output logic             abort_req,
    output logic             pwrdn_now,
    output logic             vs_eof,
    output logic             irq_en,
    output logic             pwrdn,
    output logic [PTR_W-1:0] dst,
    output logic [PTR_W-1:0] pitch,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height
);
    typedef struct packed {
        logic [PTR_W-1:0] dst;
        logic [PTR_W-1:0] pitch;
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
        logic             ien;
        logic             vs_eof;
        logic             pwrdn;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl;

    always_comb begin
        r_d     = r_q;
        wr_ctrl = reg_wr && (reg_idx == IX_CTRL);
        if (reg_wr) begin
            unique case (reg_idx)
                IX_DST: begin
                    r_d.dst = reg_wdata[PTR_W-1:0];
                    r_d.dst[DST_ALIGN-1:0] = '0;
                end
                IX_PITCH: begin
                    r_d.pitch = reg_wdata[PTR_W-1:0];
                    r_d.pitch[PITCH_ALIGN-1:0] = '0;
                end
                IX_DIM: begin
                    r_d.width  = reg_wdata[DIM_W-1:0];
                    r_d.height = reg_wdata[DIM_FLD +: DIM_W];
                end
                IX_CTRL: begin
                    r_d.ien    = reg_wdata[B_IEN];
                    r_d.vs_eof = reg_wdata[B_VS_EOF];
                    r_d.pwrdn  = reg_wdata[B_PWRDN];
                end
                default: ;
            endcase
        end
        start_req = wr_ctrl && reg_wdata[B_GO];
        abort_req = wr_ctrl && reg_wdata[B_KILL];
        pwrdn_now = r_d.pwrdn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IX_DST:   reg_rdata = REG_W'(r_q.dst);
            IX_PITCH: reg_rdata = REG_W'(r_q.pitch);
            IX_DIM: begin
                reg_rdata[DIM_W-1:0]         = r_q.width;
                reg_rdata[DIM_FLD +: DIM_W]  = r_q.height;
            end
            IX_CTRL: begin
                reg_rdata[31:24]    = ID_HI;
                reg_rdata[23:22]    = ID_LO;
                reg_rdata[B_PWRDN]  = r_q.pwrdn;
                reg_rdata[B_VS_EOF] = r_q.vs_eof;
                reg_rdata[B_IEN]    = r_q.ien;
                reg_rdata[B_BUSY]   = busy;
            end
            IX_PROG:  reg_rdata = REG_W'(progress);
            default:  reg_rdata = '0;
        endcase
    end

    assign vs_eof = r_q.vs_eof;
    assign irq_en = r_q.ien;
    assign pwrdn  = r_q.pwrdn;
    assign dst    = r_q.dst;
    assign pitch  = r_q.pitch;
    assign width  = r_q.width;
    assign height = r_q.height;
endmodule

// File: rtl/wbk_seq.sv
module wbk_seq
    import wbk_pkg::*;
#(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             abort_req,
    input  logic             pwrdn_now,
    input  logic             vs_eof,
    input  logic [DIM_W-1:0] height,
    input  logic             line_wr_done,
    input  logic             line_valid,
    output logic             busy,
    output logic [DIM_W-1:0] progress,
    output logic             vstart,
    output logic             line_accept
);
    typedef struct packed {
        seq_st_e          st;
        logic [DIM_W-1:0] prog;
        logic             vs;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.vs = 1'b0;
        if (pwrdn_now || abort_req) begin
            s_d.st = SEQ_IDLE;
        end else if (s_q.st == SEQ_IDLE) begin
            if (start_req) begin
                s_d.st   = SEQ_RUN;
                s_d.prog = '0;
                s_d.vs   = 1'b1;
            end
        end else if (s_q.prog == height) begin
            s_d.st = SEQ_IDLE;
            s_d.vs = vs_eof;
        end else if (line_wr_done) begin
            s_d.prog = s_q.prog + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, prog: '0, vs: 1'b0};
        else        s_q <= s_d;
    end

    assign busy        = (s_q.st == SEQ_RUN);
    assign progress    = s_q.prog;
    assign vstart      = s_q.vs;
    assign line_accept = line_valid && busy;
endmodule

// File: rtl/wbk_ctrl.sv
module wbk_ctrl
    import wbk_pkg::*;
#(
    parameter int DIM_W = 16,
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             line_valid,
    output logic             line_accept,
    input  logic             line_wr_done,
    output logic             vstart,
    output logic             irq,
    output logic [PTR_W-1:0] cfg_dst,
    output logic [PTR_W-1:0] cfg_pitch,
    output logic [DIM_W-1:0] cfg_width,
    output logic [DIM_W-1:0] cfg_height,
    output logic             cfg_pwrdn
);
    logic             busy_w;
    logic [DIM_W-1:0] progress_w;
    logic             start_req_w;
    logic             abort_req_w;
    logic             pwrdn_now_w;
    logic             vs_eof_w;
    logic             irq_en_w;

    wbk_regs #(.DIM_W(DIM_W), .PTR_W(PTR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy_w),
        .progress  (progress_w),
        .start_req (start_req_w),
        .abort_req (abort_req_w),
        .pwrdn_now (pwrdn_now_w),
        .vs_eof    (vs_eof_w),
        .irq_en    (irq_en_w),
        .pwrdn     (cfg_pwrdn),
        .dst       (cfg_dst),
        .pitch     (cfg_pitch),
        .width     (cfg_width),
        .height    (cfg_height)
    );

    wbk_seq #(.DIM_W(DIM_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req_w),
        .abort_req    (abort_req_w),
        .pwrdn_now    (pwrdn_now_w),
        .vs_eof       (vs_eof_w),
        .height       (cfg_height),
        .line_wr_done (line_wr_done),
        .line_valid   (line_valid),
        .busy         (busy_w),
        .progress     (progress_w),
        .vstart       (vstart),
        .line_accept  (line_accept)
    );

    assign irq = irq_en_w && !busy_w;
endmodule

// File: rtl/wbk_ctrl_chk.sv
module wbk_ctrl_chk #(
    parameter int DIM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_idx,
    input logic [31:0]      reg_wdata,
    input logic             line_wr_done,
    input logic             busy,
    input logic [DIM_W-1:0] progress,
    input logic             vstart,
    input logic             irq,
    input logic             pwrdn
);
    AST_PWRDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |-> !busy); // R10

    AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq); // R8

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> vstart); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 3'd3 && reg_wdata[14]) |=> !busy); // R9

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_wr_done) |=> $stable(progress)); // R5
endmodule

bind wbk_ctrl wbk_ctrl_chk #(.DIM_W(DIM_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_idx      (reg_idx),
    .reg_wdata    (reg_wdata),
    .line_wr_done (line_wr_done),
    .busy         (busy_w),
    .progress     (progress_w),
    .vstart       (vstart),
    .irq          (irq),
    .pwrdn        (cfg_pwrdn)
);

// File: tb/wbk_ctrl_tb_top.sv
`timescale 1ns/100ps
module wbk_ctrl_tb_top;
    localparam int K_RD = 0, K_VS = 1, K_IRQ = 2, K_ACC = 3;
    localparam logic [2:0] CT = 3'd3, PG = 3'd4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        line_valid = 1'b0;
    logic        line_accept;
    logic        line_wr_done = 1'b0;
    logic        vstart, irq, cfg_pwrdn;
    logic [31:0] cfg_dst, cfg_pitch;
    logic [15:0] cfg_width, cfg_height;

    int    checks = 0;
    int    fails = 0;
    bit    done_flag = 1'b0;
    item_t exp_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    wbk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_valid(line_valid),
        .line_accept(line_accept), .line_wr_done(line_wr_done), .vstart(vstart),
        .irq(irq), .cfg_dst(cfg_dst), .cfg_pitch(cfg_pitch), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_pwrdn(cfg_pwrdn)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(mon_ev);
            #0.2;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RD:    act = reg_rdata;
                    K_VS:    act = {31'd0, vstart};
                    K_IRQ:   act = {31'd0, irq};
                    default: act = {31'd0, line_accept};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        ->mon_ev;
        #0.4;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] e, input string tag);
        reg_idx = idx;
        push(K_RD, e, tag);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic commit();
        @(negedge clk);
        line_wr_done = 1'b1;
        @(negedge clk);
        line_wr_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        rd(CT, 32'h5440_0000, "R1 control after reset");
        rd(3'd0, 32'h0, "R1 pointer after reset");
        rd(PG, 32'h0, "R1 count after reset");
        push(K_IRQ, 0, "R1 irq after reset");

        wr(3'd0, 32'h1234_5677);
        rd(3'd0, 32'h1234_5674, "R2 pointer low bits");
        wr(3'd1, 32'h0000_0A3F);
        rd(3'd1, 32'h0000_0A30, "R2 pitch low bits");
        wr(3'd2, 32'h0003_0280);
        rd(3'd2, 32'h0003_0280, "R2 dimensions");
        rd(3'd5, 32'h0, "R2 unmapped index");

        line_valid = 1'b1;
        wr(CT, 32'h0000_8005);
        push(K_VS, 1, "R7 launch pulse");
        rd(CT, 32'h5440_8006, "R3 busy after start");
        push(K_IRQ, 0, "R8 irq low while busy");
        push(K_ACC, 1, "R11 accept while busy");
        tick();
        push(K_VS, 0, "R7 pulse one cycle");
        commit();
        rd(PG, 32'd1, "R5 first line");
        wr(CT, 32'h0000_8005);
        push(K_VS, 0, "R4 no pulse on ignored start");
        rd(PG, 32'd1, "R4 count kept");
        rd(CT, 32'h5440_8006, "R4 still busy");
        commit();
        commit();
        rd(PG, 32'd3, "R5 count reaches height");
        rd(CT, 32'h5440_8006, "R6 busy until next edge");
        tick();
        rd(CT, 32'h5440_8004, "R6 frame ended");
        push(K_VS, 1, "R7 end pulse");
        push(K_IRQ, 1, "R8 irq when idle");
        push(K_ACC, 0, "R11 no accept idle");
        rd(PG, 32'd3, "R5 count held");

        wr(CT, 32'h0);
        push(K_IRQ, 0, "R8 acknowledge");

        wr(3'd2, 32'h0002_0010);
        wr(CT, 32'h0000_0001);
        rd(PG, 32'd0, "R3 count cleared");
        commit();
        commit();
        tick();
        rd(CT, 32'h5440_0000, "R6 height two ended");
        push(K_VS, 0, "R7 no end pulse without bit15");
        commit();
        rd(PG, 32'd2, "R5 idle strobe ignored");

        wr(CT, 32'h0000_0005);
        rd(PG, 32'd0, "R3 count cleared again");
        commit();
        wr(CT, 32'h0000_4004);
        rd(CT, 32'h5440_0004, "R9 abort clears busy");
        push(K_VS, 0, "R9 no pulse on abort");
        push(K_IRQ, 1, "R9 irq after abort");
        push(K_ACC, 0, "R9 no accept after abort");
        commit();
        rd(PG, 32'd1, "R9 count frozen");
        wr(CT, 32'h0000_4005);
        rd(CT, 32'h5440_0004, "R9 abort beats start");
        push(K_VS, 0, "R9 no pulse abort with start");

        wr(CT, 32'h0020_0000);
        rd(CT, 32'h5460_0000, "R10 powerdown readback");
        wr(CT, 32'h0020_0001);
        rd(CT, 32'h5460_0000, "R10 start blocked");
        push(K_VS, 0, "R10 no pulse");
        wr(CT, 32'h0);
        wr(CT, 32'h0000_0001);
        rd(CT, 32'h5440_0002, "R10 frame running");
        wr(CT, 32'h0020_0000);
        rd(CT, 32'h5460_0000, "R10 powerdown drops busy");
        wr(CT, 32'h0);

        wr(3'd2, 32'h0000_0010);
        wr(CT, 32'h0000_0001);
        rd(CT, 32'h5440_0002, "R6 empty frame busy");
        push(K_VS, 1, "R7 empty frame launch");
        tick();
        rd(CT, 32'h5440_0000, "R6 empty frame one cycle");
        push(K_VS, 0, "R7 empty frame no end pulse");
        rd(PG, 32'd0, "R6 empty frame count");
        line_valid = 1'b0;

        tick();
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule